// File: doc/BRIEF.md
# Age-Ordered Per-Class Issue Selector

This block sits between instruction wakeup and the functional units of an out-of-order core. Ready micro-operations arrive one per cycle, each tagged with an operation class, a sequence number and a payload tag. They are held in one small sorted queue per class, so every queue feeds exactly one group of functional units. Each cycle the block grants up to `ISSUE_W` operations. It always takes the oldest ready operation whose class has a free unit.

Age comes from a sequence number that is assigned in one global order across all dynamic instructions. The selector does not compare every entry against every other entry. It keeps a registered list that holds only the head of each non-empty class queue, sorted by age. The first grant comes from walking that list from the oldest head and skipping any class that has no free unit. Later grants in the same cycle also consider the next entry of a class that has already been granted. After a grant, the new head of that class is placed back into the list at its sorted position.

A flush empties every queue and the head list in one cycle. Sequence numbers are compared as plain unsigned values. When the numbers wrap, the issue order may be out of age order for a while, but no entry is lost or issued twice.

Top module: `sel_issue_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, no grant is valid and `ins_ready` is high for every class.
- R2: Within one class, entries are granted in ascending sequence number. Entries with equal sequence numbers are granted in arrival order.
- R3: Grant slot 0 carries the entry with the lowest sequence number among the heads of classes that have at least one free unit. A tie goes to the lower class index.
- R4: A class whose `free_units` count is zero receives no grant, and in the same cycle the grant passes to the next-oldest eligible head.
- R5: At most `ISSUE_W` grants are made per cycle. Valid slots are packed from slot 0 and are in non-decreasing sequence order. Class c receives no more grants than its free count. Each further slot takes the oldest remaining eligible entry, which can be the next entry of an already granted class.
- R6: An insert accepted in cycle t can be granted no earlier than cycle t+1.
- R7: `ins_ready` is low exactly when the queue of `ins_class` already holds `DEPTH` entries. An insert offered while `ins_ready` is low is dropped.
- R8: While `flush` is high, no grant is valid, any insert offered is dropped, and every held entry is discarded, so the next cycle shows no grant.
- R9: Every accepted entry that is not discarded by a flush is granted exactly once, also when sequence numbers wrap past zero (they are compared as unsigned values).
- R10: Field positions: class c's free count sits at `free_units[c*GW +: GW]`. Grant slot s uses `gnt_class[s*CLW +: CLW]`, `gnt_seq[s*SEQ_W +: SEQ_W]` and `gnt_tag[s*TAG_W +: TAG_W]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard all held entries |
| ins_valid | input | 1 | Insert request |
| ins_class | input | CLW | Operation class of the insert |
| ins_seq | input | SEQ_W | Sequence number (age) of the insert |
| ins_tag | input | TAG_W | Payload tag of the insert |
| ins_ready | output | 1 | The queue of `ins_class` has room |
| free_units | input | NUM_CLS*GW | Free unit count per class |
| gnt_valid | output | ISSUE_W | Grant valid per slot |
| gnt_class | output | ISSUE_W*CLW | Granted class per slot |
| gnt_seq | output | ISSUE_W*SEQ_W | Granted sequence number per slot |
| gnt_tag | output | ISSUE_W*TAG_W | Granted tag per slot |

## Verification
The hardest case to reach is a second grant slot where a candidate from the head list competes with the second entry of the class that already took slot 0, while an older head is being skipped for lack of a unit. The bench builds this case directly. It parks entries with every free count at zero. It then opens two units on one class and one unit on another, so that slot 1 must choose between the two candidates. A long random phase follows. It uses shuffled sequence numbers, per-class free counts drawn each cycle, full queues and rare flushes. A behavioural reference model that always picks the oldest eligible entry is compared against the design on every cycle.

// File: rtl/sel_pkg.sv
// Package: default sizes shared by the issue selector and its bench.
// Assumes: consumers override these through module parameters when needed.
package sel_pkg;
    localparam int DEF_NUM_CLS = 4;
    localparam int DEF_DEPTH   = 4;
    localparam int DEF_SEQ_W   = 8;
    localparam int DEF_TAG_W   = 6;
    localparam int DEF_ISSUE_W = 2;
endpackage

// File: rtl/sel_class_queue.sv
// Module: sorted queue for one operation class.
// Holds up to DEPTH entries ordered by sequence number, oldest at index 0.
// Each cycle it removes pop_n entries from the head, then inserts one entry
// at its sorted position (after any entry with an equal sequence number).
// Assumes: pop_n <= cnt, and ins_en is only raised when cnt < DEPTH.
module sel_class_queue #(
    parameter int DEPTH   = sel_pkg::DEF_DEPTH,
    parameter int SEQ_W   = sel_pkg::DEF_SEQ_W,
    parameter int TAG_W   = sel_pkg::DEF_TAG_W,
    parameter int ISSUE_W = sel_pkg::DEF_ISSUE_W,
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int GW     = $clog2(ISSUE_W + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic                              ins_en,
    input  logic [SEQ_W-1:0]                  ins_seq,
    input  logic [TAG_W-1:0]                  ins_tag,
    input  logic [GW-1:0]                     pop_n,
    output logic [CW-1:0]                     cnt,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]     head_seq,
    output logic [ISSUE_W-1:0][TAG_W-1:0]     head_tag,
    output logic                              nxt_valid,
    output logic [SEQ_W-1:0]                  nxt_head
);
    logic [DEPTH-1:0][SEQ_W-1:0] q_seq, s_seq, n_seq;
    logic [DEPTH-1:0][TAG_W-1:0] q_tag, s_tag, n_tag;
    logic [CW-1:0]               s_cnt, n_cnt;
    logic [CW-1:0]               pos;

    // Shift out popped heads, then place the new entry at its sorted slot.
    always_comb begin
        s_seq = '0;
        s_tag = '0;
        for (int i = 0; i < DEPTH; i++) begin
            for (int j = 0; j <= ISSUE_W; j++) begin
                if (pop_n == GW'(j) && (i + j) < DEPTH) begin
                    s_seq[i] = q_seq[i + j];
                    s_tag[i] = q_tag[i + j];
                end
            end
        end
        s_cnt = cnt - CW'(pop_n);
        pos   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CW'(i) < s_cnt && s_seq[i] <= ins_seq) pos = CW'(i + 1);
        end
        n_seq = s_seq;
        n_tag = s_tag;
        if (ins_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (CW'(i) == pos) begin
                    n_seq[i] = ins_seq;
                    n_tag[i] = ins_tag;
                end else if (CW'(i) > pos && i > 0) begin
                    n_seq[i] = s_seq[i - 1];
                    n_tag[i] = s_tag[i - 1];
                end
            end
        end
        n_cnt     = s_cnt + CW'(ins_en);
        nxt_valid = !flush && (n_cnt != '0);
        nxt_head  = n_seq[0];
    end

    // Register the queue contents; flush or reset empties it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            q_seq <= '0;
            q_tag <= '0;
        end else if (flush) begin
            cnt <= '0;
        end else begin
            cnt   <= n_cnt;
            q_seq <= n_seq;
            q_tag <= n_tag;
        end
    end

    // Expose the first ISSUE_W entries as grant candidates.
    for (genvar k = 0; k < ISSUE_W; k++) begin : g_head
        if (k < DEPTH) begin : g_real
            assign head_seq[k] = q_seq[k];
            assign head_tag[k] = q_tag[k];
        end else begin : g_none
            assign head_seq[k] = '0;
            assign head_tag[k] = '0;
        end
    end
endmodule

// File: rtl/sel_age_list.sv
// Module: age-ordered list of class-queue heads.
// Each cycle it ranks every class whose queue will be non-empty by its next
// head sequence number (lower class index wins a tie) and registers the
// class indices in that order, oldest first.
// Assumes: NUM_CLS >= 2.
module sel_age_list #(
    parameter int NUM_CLS = sel_pkg::DEF_NUM_CLS,
    parameter int SEQ_W   = sel_pkg::DEF_SEQ_W,
    localparam int CLW    = $clog2(NUM_CLS),
    localparam int LW     = $clog2(NUM_CLS + 1)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              flush,
    input  logic [NUM_CLS-1:0]                nxt_valid,
    input  logic [NUM_CLS-1:0][SEQ_W-1:0]     nxt_head,
    output logic [NUM_CLS-1:0][CLW-1:0]       order,
    output logic [LW-1:0]                     len
);
    logic [NUM_CLS-1:0][CLW-1:0] n_order;
    logic [LW-1:0]               n_len;
    logic [LW-1:0]               rank;

    // Rank each live head against the others and drop it into its slot.
    always_comb begin
        n_order = '0;
        n_len   = '0;
        rank    = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (nxt_valid[c]) begin
                rank = '0;
                for (int d = 0; d < NUM_CLS; d++) begin
                    if (nxt_valid[d] && (nxt_head[d] < nxt_head[c] ||
                        (nxt_head[d] == nxt_head[c] && d < c)))
                        rank = rank + 1'b1;
                end
                n_order[rank] = CLW'(c);
                n_len         = n_len + 1'b1;
            end
        end
    end

    // Register the sorted list; flush or reset leaves it empty.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            order <= '0;
            len   <= '0;
        end else begin
            order <= n_order;
            len   <= n_len;
        end
    end
endmodule

// File: rtl/sel_issue_pick.sv
// Module: combinational grant selection.
// For each slot it takes the first class in the age list that has not been
// granted yet and has a free unit. It compares that with the next entry of
// every class already granted this cycle that still has units, and keeps the
// older of the two (lower class index on a tie).
// Assumes: the age list matches the current queue heads.
module sel_issue_pick #(
    parameter int NUM_CLS = sel_pkg::DEF_NUM_CLS,
    parameter int DEPTH   = sel_pkg::DEF_DEPTH,
    parameter int SEQ_W   = sel_pkg::DEF_SEQ_W,
    parameter int TAG_W   = sel_pkg::DEF_TAG_W,
    parameter int ISSUE_W = sel_pkg::DEF_ISSUE_W,
    localparam int CLW    = $clog2(NUM_CLS),
    localparam int LW     = $clog2(NUM_CLS + 1),
    localparam int CW     = $clog2(DEPTH + 1),
    localparam int GW     = $clog2(ISSUE_W + 1)
) (
    input  logic                                      en,
    input  logic [NUM_CLS-1:0][CLW-1:0]               order,
    input  logic [LW-1:0]                             len,
    input  logic [NUM_CLS-1:0][CW-1:0]                cnt,
    input  logic [NUM_CLS-1:0][GW-1:0]                free,
    input  logic [NUM_CLS-1:0][ISSUE_W-1:0][SEQ_W-1:0] cand_seq,
    input  logic [NUM_CLS-1:0][ISSUE_W-1:0][TAG_W-1:0] cand_tag,
    output logic [ISSUE_W-1:0]                        gv,
    output logic [ISSUE_W-1:0][CLW-1:0]               gc,
    output logic [ISSUE_W-1:0][SEQ_W-1:0]             gs,
    output logic [ISSUE_W-1:0][TAG_W-1:0]             gt,
    output logic [NUM_CLS-1:0][GW-1:0]                take
);
    logic               found;
    logic [CLW-1:0]     bc, wc;
    logic [SEQ_W-1:0]   bseq;
    logic [TAG_W-1:0]   btag;

    // Greedy slot-by-slot selection of the oldest eligible entry.
    always_comb begin
        take  = '0;
        gv    = '0;
        gc    = '0;
        gs    = '0;
        gt    = '0;
        found = 1'b0;
        bc    = '0;
        wc    = '0;
        bseq  = '0;
        btag  = '0;
        for (int s = 0; s < ISSUE_W; s++) begin
            found = 1'b0;
            bc    = '0;
            bseq  = '0;
            btag  = '0;
            for (int p = 0; p < NUM_CLS; p++) begin
                if (!found && LW'(p) < len) begin
                    wc = order[p];
                    if (take[wc] == '0 && free[wc] != '0) begin
                        found = 1'b1;
                        bc    = wc;
                        bseq  = cand_seq[wc][0];
                        btag  = cand_tag[wc][0];
                    end
                end
            end
            for (int c = 0; c < NUM_CLS; c++) begin
                for (int j = 1; j < ISSUE_W; j++) begin
                    if (take[c] == GW'(j) && j < int'(cnt[c]) && j < int'(free[c])) begin
                        if (!found || cand_seq[c][j] < bseq ||
                            (cand_seq[c][j] == bseq && CLW'(c) < bc)) begin
                            found = 1'b1;
                            bc    = CLW'(c);
                            bseq  = cand_seq[c][j];
                            btag  = cand_tag[c][j];
                        end
                    end
                end
            end
            if (found && en) begin
                gv[s]    = 1'b1;
                gc[s]    = bc;
                gs[s]    = bseq;
                gt[s]    = btag;
                take[bc] = take[bc] + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sel_issue_top.sv
// Module: age-ordered per-class issue selector (top).
// Routes inserts to per-class sorted queues, keeps the age list of queue
// heads and issues up to ISSUE_W grants per cycle, oldest eligible first.
// Assumes: free_units reflects units free in the current cycle; a flush
// overrides inserts and grants.
module sel_issue_top #(
    parameter int NUM_CLS = sel_pkg::DEF_NUM_CLS,
    parameter int DEPTH   = sel_pkg::DEF_DEPTH,
    parameter int SEQ_W   = sel_pkg::DEF_SEQ_W,
    parameter int TAG_W   = sel_pkg::DEF_TAG_W,
    parameter int ISSUE_W = sel_pkg::DEF_ISSUE_W,
    localparam int CLW    = $clog2(NUM_CLS),
    localparam int GW     = $clog2(ISSUE_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       flush,
    input  logic                       ins_valid,
    input  logic [CLW-1:0]             ins_class,
    input  logic [SEQ_W-1:0]           ins_seq,
    input  logic [TAG_W-1:0]           ins_tag,
    output logic                       ins_ready,
    input  logic [NUM_CLS*GW-1:0]      free_units,
    output logic [ISSUE_W-1:0]         gnt_valid,
    output logic [ISSUE_W*CLW-1:0]     gnt_class,
    output logic [ISSUE_W*SEQ_W-1:0]   gnt_seq,
    output logic [ISSUE_W*TAG_W-1:0]   gnt_tag
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int LW = $clog2(NUM_CLS + 1);

    logic [NUM_CLS-1:0][CW-1:0]                q_cnt;
    logic [NUM_CLS-1:0][ISSUE_W-1:0][SEQ_W-1:0] q_seq;
    logic [NUM_CLS-1:0][ISSUE_W-1:0][TAG_W-1:0] q_tag;
    logic [NUM_CLS-1:0]                        nx_valid;
    logic [NUM_CLS-1:0][SEQ_W-1:0]             nx_head;
    logic [NUM_CLS-1:0][GW-1:0]                take;
    logic [NUM_CLS-1:0][GW-1:0]                free_arr;
    logic [NUM_CLS-1:0][CLW-1:0]               order;
    logic [LW-1:0]                             len;
    logic [ISSUE_W-1:0][CLW-1:0]               gc;
    logic [ISSUE_W-1:0][SEQ_W-1:0]             gs;
    logic [ISSUE_W-1:0][TAG_W-1:0]             gt;
    logic                                      accept;

    // Room check for the addressed class and acceptance of the insert.
    assign ins_ready = q_cnt[ins_class] < CW'(DEPTH);
    assign accept    = ins_valid && ins_ready && !flush;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign free_arr[c] = free_units[c*GW +: GW];
        sel_class_queue #(
            .DEPTH(DEPTH), .SEQ_W(SEQ_W), .TAG_W(TAG_W), .ISSUE_W(ISSUE_W)
        ) u_queue (
            .clk      (clk),
            .rst_n    (rst_n),
            .flush    (flush),
            .ins_en   (accept && ins_class == CLW'(c)),
            .ins_seq  (ins_seq),
            .ins_tag  (ins_tag),
            .pop_n    (take[c]),
            .cnt      (q_cnt[c]),
            .head_seq (q_seq[c]),
            .head_tag (q_tag[c]),
            .nxt_valid(nx_valid[c]),
            .nxt_head (nx_head[c])
        );
    end

    sel_age_list #(.NUM_CLS(NUM_CLS), .SEQ_W(SEQ_W)) u_age (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .nxt_valid(nx_valid),
        .nxt_head (nx_head),
        .order    (order),
        .len      (len)
    );

    sel_issue_pick #(
        .NUM_CLS(NUM_CLS), .DEPTH(DEPTH), .SEQ_W(SEQ_W),
        .TAG_W(TAG_W), .ISSUE_W(ISSUE_W)
    ) u_pick (
        .en      (!flush),
        .order   (order),
        .len     (len),
        .cnt     (q_cnt),
        .free    (free_arr),
        .cand_seq(q_seq),
        .cand_tag(q_tag),
        .gv      (gnt_valid),
        .gc      (gc),
        .gs      (gs),
        .gt      (gt),
        .take    (take)
    );

    // Flatten per-slot grant fields onto the output buses.
    for (genvar s = 0; s < ISSUE_W; s++) begin : g_slot
        assign gnt_class[s*CLW +: CLW]   = gc[s];
        assign gnt_seq[s*SEQ_W +: SEQ_W] = gs[s];
        assign gnt_tag[s*TAG_W +: TAG_W] = gt[s];
    end
endmodule

// File: rtl/sel_issue_chk.sv
// Module: assertion checker for sel_issue_top, attached by bind.
// Observes only the top-level ports.
module sel_issue_chk #(
    parameter int NUM_CLS = sel_pkg::DEF_NUM_CLS,
    parameter int SEQ_W   = sel_pkg::DEF_SEQ_W,
    parameter int ISSUE_W = sel_pkg::DEF_ISSUE_W,
    localparam int CLW    = $clog2(NUM_CLS),
    localparam int GW     = $clog2(ISSUE_W + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     flush,
    input logic                     ins_ready,
    input logic [NUM_CLS*GW-1:0]    free_units,
    input logic [ISSUE_W-1:0]       gnt_valid,
    input logic [ISSUE_W*CLW-1:0]   gnt_class,
    input logic [ISSUE_W*SEQ_W-1:0] gnt_seq
);
    logic [NUM_CLS-1:0][GW-1:0] per_cls;

    // Count the grants given to each class in this cycle.
    always_comb begin
        per_cls = '0;
        for (int c = 0; c < NUM_CLS; c++) begin
            for (int s = 0; s < ISSUE_W; s++) begin
                if (gnt_valid[s] && gnt_class[s*CLW +: CLW] == CLW'(c))
                    per_cls[c] = per_cls[c] + 1'b1;
            end
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> gnt_valid == '0); // R1
    AST_RESET_READY: assert property (@(posedge clk) !rst_n |=> ins_ready); // R1
    AST_FLUSH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> gnt_valid == '0); // R8
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> gnt_valid == '0); // R8

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_unit
        AST_UNIT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
            per_cls[c] <= free_units[c*GW +: GW]); // R5
    end

    for (genvar s = 1; s < ISSUE_W; s++) begin : g_order
        AST_SLOT_PACKED: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[s] |-> gnt_valid[s-1]); // R5
        AST_SLOT_AGE: assert property (@(posedge clk) disable iff (!rst_n)
            gnt_valid[s] |-> gnt_seq[(s-1)*SEQ_W +: SEQ_W] <= gnt_seq[s*SEQ_W +: SEQ_W]); // R5
    end
endmodule

bind sel_issue_top sel_issue_chk #(
    .NUM_CLS(NUM_CLS), .SEQ_W(SEQ_W), .ISSUE_W(ISSUE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush),
    .ins_ready (ins_ready),
    .free_units(free_units),
    .gnt_valid (gnt_valid),
    .gnt_class (gnt_class),
    .gnt_seq   (gnt_seq)
);

// File: tb/test_sel_issue_top.sv
// Bench: behavioural reference model (per-class queues, greedy oldest pick)
// compared against the design on every clock.
module test_sel_issue_top;
    localparam int CLK_PERIOD = 10;
    localparam int NC = 4, DEPTH = 4, SEQ_W = 8, TAG_W = 6, IW = 2;
    localparam int CLW = 2, GW = 2;

    logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, ins_valid = 1'b0;
    logic [CLW-1:0] ins_class = '0;
    logic [SEQ_W-1:0] ins_seq = '0;
    logic [TAG_W-1:0] ins_tag = '0;
    logic ins_ready;
    logic [NC*GW-1:0] free_units = '0;
    logic [IW-1:0] gnt_valid;
    logic [IW*CLW-1:0] gnt_class;
    logic [IW*SEQ_W-1:0] gnt_seq;
    logic [IW*TAG_W-1:0] gnt_tag;

    int n_chk = 0, n_fail = 0;
    int mseq[NC][$];
    int mtag[NC][$];
    int fr[NC];
    int acc_cnt = 0, gnt_cnt = 0, drop_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sel_issue_top i_sel_issue_top (
        .clk(clk), .rst_n(rst_n), .flush(flush), .ins_valid(ins_valid),
        .ins_class(ins_class), .ins_seq(ins_seq), .ins_tag(ins_tag),
        .ins_ready(ins_ready), .free_units(free_units), .gnt_valid(gnt_valid),
        .gnt_class(gnt_class), .gnt_seq(gnt_seq), .gnt_tag(gnt_tag)
    );

    task automatic chk(string rq, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic set_ins(bit v, int c, int s, int t);
        ins_valid = v;
        ins_class = CLW'(c);
        ins_seq   = SEQ_W'(s);
        ins_tag   = TAG_W'(t);
    endtask

    task automatic set_free(int a, int b, int c, int d);
        fr[0] = a; fr[1] = b; fr[2] = c; fr[3] = d;
    endtask

    // One clock: compare outputs with the model, then advance the model.
    task automatic tick(string rq);
        int k[NC];
        int ev[IW], ec[IW], es[IW], et[IW];
        int rdy, cls, pos;
        for (int c = 0; c < NC; c++) free_units[c*GW +: GW] = GW'(fr[c]);
        #1;
        cls = int'(ins_class);
        rdy = (mseq[cls].size() < DEPTH) ? 1 : 0;
        chk(rq, "ins_ready", int'(ins_ready), rdy);
        for (int c = 0; c < NC; c++) k[c] = 0;
        for (int s = 0; s < IW; s++) begin
            ev[s] = 0; ec[s] = 0; es[s] = 0; et[s] = 0;
            if (!flush) begin
                for (int c = 0; c < NC; c++) begin
                    if (k[c] < mseq[c].size() && k[c] < fr[c]) begin
                        if (ev[s] == 0 || mseq[c][k[c]] < es[s]) begin
                            ev[s] = 1; ec[s] = c;
                            es[s] = mseq[c][k[c]]; et[s] = mtag[c][k[c]];
                        end
                    end
                end
                if (ev[s] != 0) k[ec[s]]++;
            end
            // R10 field positions: slot s at [s*W +: W]
            chk(rq, $sformatf("gnt_valid[%0d]", s), int'(gnt_valid[s]), ev[s]);
            if (ev[s] != 0) begin
                chk(rq, $sformatf("gnt_class[%0d]", s), int'(gnt_class[s*CLW +: CLW]), ec[s]);
                chk(rq, $sformatf("gnt_seq[%0d]", s), int'(gnt_seq[s*SEQ_W +: SEQ_W]), es[s]);
                chk(rq, $sformatf("gnt_tag[%0d]", s), int'(gnt_tag[s*TAG_W +: TAG_W]), et[s]);
            end
        end
        for (int s = 0; s < IW; s++) begin
            if (ev[s] != 0) begin
                void'(mseq[ec[s]].pop_front());
                void'(mtag[ec[s]].pop_front());
                gnt_cnt++;
            end
        end
        if (flush) begin
            for (int c = 0; c < NC; c++) begin
                drop_cnt += mseq[c].size();
                mseq[c].delete();
                mtag[c].delete();
            end
        end else if (ins_valid && rdy == 1) begin
            pos = mseq[cls].size();
            for (int i = mseq[cls].size() - 1; i >= 0; i--)
                if (mseq[cls][i] > int'(ins_seq)) pos = i;
            mseq[cls].insert(pos, int'(ins_seq));
            mtag[cls].insert(pos, int'(ins_tag));
            acc_cnt++;
        end
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int total, base;
        set_free(0, 0, 0, 0);
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        #1;
        chk("R1", "gnt_valid in reset", int'(gnt_valid), 0);
        chk("R1", "ins_ready in reset", int'(ins_ready), 1);
        @(negedge clk);
        rst_n = 1'b1;
        tick("R1");

        // R2: out-of-order arrivals in one class, one tie
        set_ins(1, 1, 30, 1); tick("R2");
        set_ins(1, 1, 10, 2); tick("R2");
        set_ins(1, 1, 20, 3); tick("R2");
        set_ins(1, 1, 10, 4); tick("R2");
        set_ins(0, 0, 0, 0); set_free(0, 1, 0, 0);
        repeat (5) tick("R2");

        // R6: an entry is not granted in the cycle it arrives
        set_free(1, 1, 1, 1);
        set_ins(1, 2, 5, 9); tick("R6");
        set_ins(0, 0, 0, 0); tick("R6");

        // R4: the oldest head is blocked, the next heads issue
        set_free(0, 0, 0, 0);
        set_ins(1, 0, 3, 10); tick("R4");
        set_ins(1, 2, 9, 11); tick("R4");
        set_ins(1, 3, 7, 12); tick("R4");
        set_ins(0, 0, 0, 0); set_free(0, 0, 1, 1); tick("R4");
        set_free(1, 0, 0, 0); tick("R3");

        // R5: two grants to one class versus an older head elsewhere
        set_free(0, 0, 0, 0);
        set_ins(1, 1, 41, 20); tick("R5");
        set_ins(1, 1, 40, 21); tick("R5");
        set_ins(1, 1, 42, 22); tick("R5");
        set_ins(1, 0, 100, 23); tick("R5");
        set_ins(1, 2, 35, 24); tick("R5");
        set_ins(0, 0, 0, 0); set_free(1, 2, 0, 0);
        for (int c = 0; c < NC; c++) free_units[c*GW +: GW] = GW'(fr[c]);
        #1;
        chk("R10", "slot1 class field", int'(gnt_class[CLW +: CLW]), 1);
        chk("R10", "slot1 seq field", int'(gnt_seq[SEQ_W +: SEQ_W]), 41);
        tick("R5");
        set_free(2, 2, 2, 2);
        repeat (3) tick("R5");

        // R7: fill one class past its depth
        set_free(0, 0, 0, 0);
        base = gnt_cnt;
        for (int i = 0; i < DEPTH + 2; i++) begin
            set_ins(1, 3, 60 - i, 30 + i); tick("R7");
        end
        set_ins(0, 3, 0, 0); set_free(0, 0, 0, 1);
        repeat (DEPTH + 2) tick("R7");
        chk("R7", "grants after overfill", gnt_cnt - base, DEPTH);

        // R8: flush with held entries and a concurrent insert
        set_free(0, 0, 0, 0);
        set_ins(1, 0, 1, 1); tick("R8");
        set_ins(1, 2, 2, 2); tick("R8");
        set_free(2, 2, 2, 2); flush = 1'b1;
        set_ins(1, 1, 3, 3); tick("R8");
        flush = 1'b0; set_ins(0, 0, 0, 0);
        #1;
        chk("R8", "grant after flush", int'(gnt_valid), 0);
        tick("R8");
        tick("R8");

        // R9: sequence numbers that wrap past zero
        set_free(0, 0, 0, 0);
        for (int i = 0; i < 12; i++) begin
            set_ins(1, i % NC, (250 + i) % 256, i); tick("R9");
        end
        set_ins(0, 0, 0, 0); set_free(1, 2, 1, 2);
        repeat (10) tick("R9");

        // R3: random traffic against the model
        for (int n = 0; n < 3000; n++) begin
            set_ins(($urandom % 3) != 0, $urandom % NC, $urandom % 256, $urandom % 64);
            set_free($urandom % 3, $urandom % 3, $urandom % 3, $urandom % 3);
            if (($urandom % 5) == 0) set_free(0, 0, 0, 0);
            flush = (($urandom % 97) == 0);
            tick("R3");
        end
        flush = 1'b0;

        // R9: drain and account for every accepted entry
        set_ins(0, 0, 0, 0); set_free(2, 2, 2, 2);
        repeat (12) tick("R9");
        total = 0;
        for (int c = 0; c < NC; c++) total += mseq[c].size();
        chk("R9", "model entries left", total, 0);
        chk("R9", "accepted vs granted+dropped", acc_cnt, gnt_cnt + drop_cnt);
        #1;
        chk("R9", "design idle after drain", int'(gnt_valid), 0);

        summary();
        $finish;
    end
endmodule